// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block holds the floating-point control and status word of a coprocessor that sits beside a 32-bit CPU, and turns the exception report of each finished floating-point operation into status bits, an interrupt level and a result-write veto. Each operation reports up to five exception kinds plus an "operation not implemented" condition. The block records them as the cause of that operation, folds them into accumulating flags, and compares them against the software enables to decide whether an exception is pending.

The interrupt line is a level. It is recomputed after every reported operation and after every CPU write to the status word, so it drops again as soon as a later operation finishes cleanly or software clears the cause or enable bits. The veto output is combinational: in the same cycle an operation is reported with an enabled or unimplemented exception, it tells the datapath not to write the destination register.

The operation report has no back-pressure: the block accepts one report on every cycle where `op_valid` is high, and `op_valid` low means no operation finished that cycle. The CPU write port and all outputs are plain control pins.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset, `csr_value` reads 0 and `irq` is low.
- R2: A report loads the cause field (bits 16:12) with `op_exc` and bit 17 with `op_unimpl`, replacing the previous cause in full. Exception bit order in `op_exc` and in all three fields, low to high: inexact, underflow, overflow, divide-by-zero, invalid.
- R3: A report ORs `op_exc` into the flag field (bits 6:2); flags are never cleared by a report.
- R4: An exception is pending when bit 17 is set, or when any cause bit is set together with the enable bit (bits 11:7) of the same kind.
- R5: One cycle after a report, `irq` is high if the new state has a pending exception and low otherwise; it clears as well as sets.
- R6: `wb_block` is high in the cycle of a report exactly when `op_unimpl` is high or `op_exc` shares a set bit with the current enables; it is low whenever `op_valid` is low.
- R7: A CPU write loads bits 17:2 from `wr_data` on the next cycle; all other bits always read 0; `irq` then reflects the pending-exception test on the written fields.
- R8: When a write and a report arrive in the same cycle, the write defines the next status word and `irq`; the report only affects `wb_block`.
- R9: With neither a report nor a write, `csr_value` and `irq` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation finished this cycle |
| op_exc | input | 5 | Exception kinds raised by that operation |
| op_unimpl | input | 1 | Operation could not be executed |
| wr_en | input | 1 | CPU writes the status word |
| wr_data | input | 32 | Value written by the CPU |
| csr_value | output | 32 | Current status word |
| irq | output | 1 | Level interrupt, high while an exception is pending |
| wb_block | output | 1 | Suppress the destination register write of this operation |

## Verification
The bench builds the unit with its default field base of bit 2 and a 32-bit word, the layout software sees, so every field position named in the requirements is checked as an absolute bit. With five exception kinds the enable and cause combinations are few enough to walk each kind alone with and without its enable, which makes the clear-after-set path of the interrupt and the write-versus-report collision reachable in a short directed run.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  // number of exception kinds carried in every field
  localparam int unsigned EXC_N = 5;

  // bit index of each kind inside a field
  localparam int unsigned K_INEXACT   = 0;
  localparam int unsigned K_UNDERFLOW = 1;
  localparam int unsigned K_OVERFLOW  = 2;
  localparam int unsigned K_DIVZERO   = 3;
  localparam int unsigned K_INVALID   = 4;

  typedef logic [EXC_N-1:0] kinds_t;

  typedef struct packed {
    logic   unimpl;
    kinds_t cause;
    kinds_t enable;
    kinds_t flags;
  } fpx_state_t;
endpackage

// File: rtl/fpx_exc_detect.sv
module fpx_exc_detect
  import fpx_pkg::*;
(
  input  kinds_t cause,
  input  logic   unimpl,
  input  kinds_t enable,
  output logic   pending
);
  kinds_t armed;

  always_comb begin
    for (int k = 0; k < int'(EXC_N); k++) begin
      armed[k] = cause[k] & enable[k];
    end
    pending = unimpl | (|armed);
  end
endmodule

// File: rtl/fpx_csr_map.sv
module fpx_csr_map
  import fpx_pkg::*;
#(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned FLAG_LSB = 2
) (
  input  fpx_state_t       st,
  output logic [REG_W-1:0] word,
  input  logic [REG_W-1:0] wr_word,
  output fpx_state_t       wr_st
);
  localparam int unsigned EN_LSB    = FLAG_LSB + EXC_N;
  localparam int unsigned CAUSE_LSB = EN_LSB + EXC_N;
  localparam int unsigned UNIMP_BIT = CAUSE_LSB + EXC_N;

  initial begin
    if (UNIMP_BIT >= REG_W) $error("fpx_csr_map: fields exceed word width");
  end

  // pack: fields into the software-visible word, everything else zero
  always_comb begin
    word = '0;
    word[FLAG_LSB  +: EXC_N] = st.flags;
    word[EN_LSB    +: EXC_N] = st.enable;
    word[CAUSE_LSB +: EXC_N] = st.cause;
    word[UNIMP_BIT]          = st.unimpl;
  end

  // unpack: only the defined fields of a written word are kept
  always_comb begin
    wr_st.flags  = wr_word[FLAG_LSB  +: EXC_N];
    wr_st.enable = wr_word[EN_LSB    +: EXC_N];
    wr_st.cause  = wr_word[CAUSE_LSB +: EXC_N];
    wr_st.unimpl = wr_word[UNIMP_BIT];
  end
endmodule

// File: rtl/fpx_next_state.sv
module fpx_next_state
  import fpx_pkg::*;
(
  input  fpx_state_t cur,
  input  logic       op_valid,
  input  kinds_t     op_exc,
  input  logic       op_unimpl,
  input  logic       wr_en,
  input  fpx_state_t wr_st,
  output fpx_state_t nxt,
  output logic       upd
);
  always_comb begin
    nxt = cur;
    upd = 1'b0;
    if (wr_en) begin
      // software write takes the whole word
      nxt = wr_st;
      upd = 1'b1;
    end else if (op_valid) begin
      // previous cause is dropped, the new report replaces it
      nxt.cause  = op_exc;
      nxt.unimpl = op_unimpl;
      nxt.flags  = cur.flags | op_exc;
      upd        = 1'b1;
    end
  end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned FLAG_LSB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [4:0]       op_exc,
  input  logic             op_unimpl,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] csr_value,
  output logic             irq,
  output logic             wb_block
);
  localparam int unsigned EN_LSB    = FLAG_LSB + EXC_N;
  localparam int unsigned CAUSE_LSB = EN_LSB + EXC_N;
  localparam int unsigned UNIMP_BIT = CAUSE_LSB + EXC_N;

  fpx_state_t st_q, st_d, wr_st;
  logic       upd;
  logic       pend_op, pend_next;

  fpx_csr_map #(.REG_W(REG_W), .FLAG_LSB(FLAG_LSB)) u_map (
    .st      (st_q),
    .word    (csr_value),
    .wr_word (wr_data),
    .wr_st   (wr_st)
  );

  fpx_next_state u_next (
    .cur       (st_q),
    .op_valid  (op_valid),
    .op_exc    (op_exc),
    .op_unimpl (op_unimpl),
    .wr_en     (wr_en),
    .wr_st     (wr_st),
    .nxt       (st_d),
    .upd       (upd)
  );

  // veto for the operation reported in this cycle, against live enables
  fpx_exc_detect u_det_op (
    .cause   (op_exc),
    .unimpl  (op_unimpl),
    .enable  (st_q.enable),
    .pending (pend_op)
  );

  // pending test on the state about to be stored
  fpx_exc_detect u_det_next (
    .cause   (st_d.cause),
    .unimpl  (st_d.unimpl),
    .enable  (st_d.enable),
    .pending (pend_next)
  );

  assign wb_block = op_valid & pend_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      irq  <= 1'b0;
    end else if (upd) begin
      st_q <= st_d;
      irq  <= pend_next;
    end
  end

  // R5: the level always matches the stored fields after any update
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid || wr_en) |=> irq == (csr_value[UNIMP_BIT] ||
      (|(csr_value[CAUSE_LSB +: EXC_N] & csr_value[EN_LSB +: EXC_N]))));

  // R3: a report never clears a flag
  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en) |=> ((csr_value[FLAG_LSB +: EXC_N] &
      $past(csr_value[FLAG_LSB +: EXC_N])) == $past(csr_value[FLAG_LSB +: EXC_N])));

  // R2: cause field carries the last report
  a_r2_cause_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en) |=> (csr_value[CAUSE_LSB +: EXC_N] == $past(op_exc)) &&
      (csr_value[UNIMP_BIT] == $past(op_unimpl)));

  // R6: an unimplemented operation is always vetoed, nothing is vetoed when idle
  a_r6_unimpl_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_unimpl) |-> wb_block);
  a_r6_idle_no_block: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !wb_block);

  // R9: nothing moves without a report or a write
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !wr_en) |=> $stable(csr_value) && $stable(irq));

  // R7: undefined bits stay zero
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_value[FLAG_LSB-1:0] == '0) && (csr_value[REG_W-1:UNIMP_BIT+1] == '0));
endmodule

// File: tb/test_fpx_status_unit.sv
module test_fpx_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_exc = '0;
  logic        op_unimpl = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] csr_value;
  logic        irq, wb_block;

  int errors = 0;
  int checks = 0;

  // reference state
  logic [31:0] m_csr = '0;
  logic        m_irq = 1'b0;

  always #2 clk = ~clk;

  fpx_status_unit i_fpx_status_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_exc(op_exc),
    .op_unimpl(op_unimpl), .wr_en(wr_en), .wr_data(wr_data),
    .csr_value(csr_value), .irq(irq), .wb_block(wb_block)
  );

  function automatic logic pend(input logic [31:0] w);
    return w[17] | (|((w >> 12) & (w >> 7) & 32'h1f));
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check veto, update model at posedge, check state at next negedge
  task automatic cyc(input string tag, input logic v, input logic [4:0] e, input logic u,
                     input logic w, input logic [31:0] d);
    logic exp_blk;
    logic [31:0] tmp;
    @(negedge clk);
    op_valid = v; op_exc = e; op_unimpl = u; wr_en = w; wr_data = d;
    #1;
    exp_blk = v & (u | (|(e & m_csr[11:7])));
    chk(tag, "wb_block", {31'b0, wb_block}, {31'b0, exp_blk});
    @(posedge clk);
    if (w) begin
      m_csr = d & 32'h0003_fffc;
      m_irq = pend(m_csr);
    end else if (v) begin
      tmp = m_csr & ~32'h0003_f000;
      tmp = tmp | ({27'b0, e} << 12) | ({31'b0, u} << 17) | ({27'b0, e} << 2);
      m_csr = tmp;
      m_irq = pend(m_csr);
    end
    @(negedge clk);
    chk(tag, "csr_value", csr_value, m_csr);
    chk(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
    op_valid = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "csr_value after reset", csr_value, 32'h0);
    chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;

    // R2/R3: reports with no enables, each kind alone
    for (int k = 0; k < 5; k++) cyc("R2", 1'b1, 5'(1 << k), 1'b0, 1'b0, '0);
    cyc("R3", 1'b1, 5'b00000, 1'b0, 1'b0, '0);
    cyc("R9", 1'b0, 5'b11111, 1'b1, 1'b0, '0);
    // R4/R5: unimplemented alone asserts, clean op clears
    cyc("R4", 1'b1, 5'b00000, 1'b1, 1'b0, '0);
    cyc("R5", 1'b1, 5'b00000, 1'b0, 1'b0, '0);
    // R7: write enables (invalid, divzero), junk in reserved bits
    cyc("R7", 1'b0, '0, 1'b0, 1'b1, 32'hfffc_0003 | (32'h18 << 7));
    // R4/R6: each kind with enables set
    for (int k = 0; k < 5; k++) cyc("R6", 1'b1, 5'(1 << k), 1'b0, 1'b0, '0);
    cyc("R5", 1'b1, 5'b00011, 1'b0, 1'b0, '0);
    cyc("R9", 1'b0, '0, 1'b0, 1'b0, '0);
    // R7: write a pending exception directly, then clear it
    cyc("R7", 1'b0, '0, 1'b0, 1'b1, (32'h1 << 12) | (32'h1 << 7));
    cyc("R9", 1'b0, '0, 1'b0, 1'b0, '0);
    cyc("R7", 1'b0, '0, 1'b0, 1'b1, (32'h1 << 12));
    // R8: collision, write wins but veto still follows live enables
    cyc("R7", 1'b0, '0, 1'b0, 1'b1, (32'h1f << 7));
    cyc("R8", 1'b1, 5'b10000, 1'b0, 1'b1, 32'h0000_0000);
    cyc("R8", 1'b1, 5'b00001, 1'b1, 1'b1, (32'h1 << 12) | (32'h1 << 7));
    // R3: flags accumulate across several reports
    cyc("R7", 1'b0, '0, 1'b0, 1'b1, 32'h0);
    cyc("R3", 1'b1, 5'b00101, 1'b0, 1'b0, '0);
    cyc("R3", 1'b1, 5'b01000, 1'b0, 1'b0, '0);
    cyc("R3", 1'b1, 5'b10000, 1'b1, 1'b0, '0);
    cyc("R5", 1'b1, 5'b00000, 1'b0, 1'b0, '0);
    // sweep of mixed patterns
    for (int i = 0; i < 40; i++) begin
      cyc("R6", 1'b1, 5'((i * 7) % 32), i % 9 == 0, 1'b0, '0);
      if (i % 10 == 3) cyc("R7", 1'b0, '0, 1'b0, 1'b1, 32'(i * 32'h1234_5679));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule